// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps the time of day and the calendar date in packed BCD registers. Each one-second tick starts one update. The update carries from seconds through minutes, hours, date, month and two-digit year. It knows the length of each month and adds a 29th of February in leap years. A byte-wide register port, driven by a bus bridge inside the chip, reads and writes every field. The same port reaches three alarm compare registers, a control register and a status register. All reads are combinational from the address.

Software sets the freeze bit, loads the time and clears the bit again. Before reading the time, it polls the update-busy flag. The flag goes high a fixed number of cycles before any field changes and stays high until the update ends. The update is a chain of named states: `ST_IDLE`, `ST_LEAD`, `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DATE`, `ST_MON`, `ST_YEAR` and `ST_ALARM`.
- `ST_IDLE` goes to `ST_LEAD` on a tick while not frozen.
- `ST_LEAD` holds for `UIP_LEAD` cycles and then goes to `ST_SEC`.
- Each field state steps its field. It moves to the next field state if that field wrapped, and otherwise to `ST_ALARM`. `ST_MON` moves to `ST_YEAR` only on a December wrap.
- `ST_YEAR` always goes to `ST_ALARM`.
- `ST_ALARM` compares the time with the alarm registers and returns to `ST_IDLE`.
- Any state other than `ST_IDLE` returns to `ST_IDLE` at once when freeze is set.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the registers read as follows: seconds, minutes, hours, year and all alarms 0x00; date, month and weekday 0x01; control 0x02 (24-hour, running); busy 0x00; status 0x00. The `uip` and `alarm_flag` outputs are 0.
- R2: The port uses these byte addresses. Year 0x9, month 0x8, date 0x7, weekday 0x6, hours 0x4, minutes 0x2, seconds 0x0. Alarm hours 0x5, alarm minutes 0x3, alarm seconds 0x1. Busy register 0xA, control 0xB, status 0xC. Written values are masked: seconds and minutes to 0x7F, date and 24-hour hours to 0x3F, 12-hour hours to 0x9F, month to 0x1F, weekday to 0x07. Writes to 0xA have no effect. Control keeps only bit 7 (freeze) and bit 1 (24-hour).
- R3: Each tick adds one to seconds in BCD (x9 goes to (x+1)0) when there is no wider carry.
- R4: In 24-hour mode seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the date. BCD digit carries apply at each step.
- R5: In 12-hour mode hours bit 7 is PM. The hour runs 12, 01, ..., 11. The step from 11 to 12 toggles PM. Only the step from 11 PM to 12 AM carries into the date.
- R6: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R7: February ends at day 29 when the BCD year is divisible by 4, and at day 28 otherwise.
- R8: Weekday steps once on every date carry and wraps from 7 to 1.
- R9: While control bit 7 is set, ticks are ignored, `uip` reads 0 and no field steps. Setting the bit during an update abandons the update. Clearing the bit lets later ticks count again.
- R10: `uip` (also busy register bit 7) rises the cycle after a tick is taken. Seconds change exactly `UIP_LEAD`+1 clock edges after that tick edge. `uip` falls one edge after the last field step.
- R11: When an update ends with seconds, minutes and hours each equal to their alarm registers, `alarm_flag` is set and status bit 5 reads 1. A write of any value to 0xC clears it. An update that does not match leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| uip | output | 1 | Update in progress |
| alarm_flag | output | 1 | Alarm match seen, held until cleared |

## Verification
The bench walks full rollover chains from 23:59:59 across the last day of 30-day and 31-day months, the year end, and February in leap and plain years. Those years include 00, 12, 96 and 98. A wrong leap test would stop February on the wrong day. A wrong month table would skip or add a day.

The 12-hour cases cover the 11-to-12 PM toggle, the 12-to-01 step and the midnight date carry. A design that toggled PM at the wrong hour, or carried the date at noon, would miscompare there.

The exact edge on which seconds change after a tick is measured. So is freeze applied in the middle of an update. A design with a shorter busy window, or one that let a step land after freeze, is caught.

// File: rtl/clk_core_pkg.sv
package clk_core_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SEC   = 4'h0;
    localparam logic [ADDR_W-1:0] A_ASEC  = 4'h1;
    localparam logic [ADDR_W-1:0] A_MIN   = 4'h2;
    localparam logic [ADDR_W-1:0] A_AMIN  = 4'h3;
    localparam logic [ADDR_W-1:0] A_HOUR  = 4'h4;
    localparam logic [ADDR_W-1:0] A_AHOUR = 4'h5;
    localparam logic [ADDR_W-1:0] A_DOW   = 4'h6;
    localparam logic [ADDR_W-1:0] A_DATE  = 4'h7;
    localparam logic [ADDR_W-1:0] A_MON   = 4'h8;
    localparam logic [ADDR_W-1:0] A_YEAR  = 4'h9;
    localparam logic [ADDR_W-1:0] A_BUSY  = 4'hA;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'hB;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'hC;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DATE,
        ST_MON,
        ST_YEAR,
        ST_ALARM
    } upd_state_e;

    // add one to a packed two-digit BCD byte
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = v + 8'd1;
        return r;
    endfunction

endpackage

// File: rtl/clk_month_limit.sv
module clk_month_limit (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic leap;

    // BCD year divisible by 4: even tens with 0/4/8, odd tens with 2/6
    always_comb begin
        if (year[4]) leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        else         leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) ||
                            (year[3:0] == 4'd8);
    end

    always_comb begin
        unique case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/clk_update_fsm.sv
module clk_update_fsm
    import clk_core_pkg::*;
#(
    parameter int UIP_LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    input  logic sec_wrap,
    input  logic min_wrap,
    input  logic hour_wrap,
    input  logic date_wrap,
    input  logic mon_wrap,
    output logic step_sec,
    output logic step_min,
    output logic step_hour,
    output logic step_date,
    output logic step_mon,
    output logic step_year,
    output logic alarm_chk,
    output logic busy
);
    localparam int CNT_W = (UIP_LEAD < 2) ? 1 : $clog2(UIP_LEAD);

    upd_state_e state_q, state_d;
    logic [CNT_W-1:0] lead_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick) state_d = ST_LEAD;
            ST_LEAD:  if (lead_cnt_q == '0) state_d = ST_SEC;
            ST_SEC:   state_d = sec_wrap  ? ST_MIN  : ST_ALARM;
            ST_MIN:   state_d = min_wrap  ? ST_HOUR : ST_ALARM;
            ST_HOUR:  state_d = hour_wrap ? ST_DATE : ST_ALARM;
            ST_DATE:  state_d = date_wrap ? ST_MON  : ST_ALARM;
            ST_MON:   state_d = mon_wrap  ? ST_YEAR : ST_ALARM;
            ST_YEAR:  state_d = ST_ALARM;
            ST_ALARM: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (freeze) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lead_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_LEAD)
                lead_cnt_q <= CNT_W'(UIP_LEAD - 1);
            else if (state_q == ST_LEAD && lead_cnt_q != '0)
                lead_cnt_q <= lead_cnt_q - 1'b1;
        end
    end

    always_comb begin
        step_sec  = 1'b0;
        step_min  = 1'b0;
        step_hour = 1'b0;
        step_date = 1'b0;
        step_mon  = 1'b0;
        step_year = 1'b0;
        alarm_chk = 1'b0;
        busy      = 1'b0;
        if (!freeze) begin
            busy = (state_q != ST_IDLE);
            unique case (state_q)
                ST_SEC:   step_sec  = 1'b1;
                ST_MIN:   step_min  = 1'b1;
                ST_HOUR:  step_hour = 1'b1;
                ST_DATE:  step_date = 1'b1;
                ST_MON:   step_mon  = 1'b1;
                ST_YEAR:  step_year = 1'b1;
                ST_ALARM: alarm_chk = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/clk_time_regs.sv
module clk_time_regs
    import clk_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              step_sec,
    input  logic              step_min,
    input  logic              step_hour,
    input  logic              step_date,
    input  logic              step_mon,
    input  logic              step_year,
    input  logic              alarm_chk,
    input  logic              busy,
    input  logic [7:0]        last_date,
    output logic              sec_wrap,
    output logic              min_wrap,
    output logic              hour_wrap,
    output logic              date_wrap,
    output logic              mon_wrap,
    output logic              freeze,
    output logic              alarm_flag,
    output logic [7:0]        sec,
    output logic [7:0]        min,
    output logic [7:0]        hour,
    output logic [7:0]        dow,
    output logic [7:0]        date,
    output logic [7:0]        month,
    output logic [7:0]        year,
    output logic [7:0]        asec,
    output logic [7:0]        amin,
    output logic [7:0]        ahour
);
    logic       h24;
    logic [7:0] hour_nx, h12_low, dow_nx;
    logic       match;

    assign sec_wrap  = (sec == 8'h59);
    assign min_wrap  = (min == 8'h59);
    assign hour_wrap = h24 ? (hour == 8'h23) : (hour[7] && hour[4:0] == 5'h11);
    assign date_wrap = (date == last_date);
    assign mon_wrap  = (month == 8'h12);
    assign match     = (sec == asec) && (min == amin) && (hour == ahour);
    assign h12_low   = bcd_inc({3'b000, hour[4:0]});

    always_comb begin
        if (h24)                       hour_nx = hour_wrap ? 8'h00 : bcd_inc(hour);
        else if (hour[4:0] == 5'h12)   hour_nx = {hour[7], 7'h01};
        else if (hour[4:0] == 5'h11)   hour_nx = {~hour[7], 7'h12};
        else                           hour_nx = {hour[7], h12_low[6:0]};
        dow_nx = (dow >= 8'd7 || dow == 8'd0) ? 8'h01 : dow + 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec <= 8'h00; min <= 8'h00; hour <= 8'h00;
            dow <= 8'h01; date <= 8'h01; month <= 8'h01; year <= 8'h00;
            asec <= 8'h00; amin <= 8'h00; ahour <= 8'h00;
            h24 <= 1'b1; freeze <= 1'b0; alarm_flag <= 1'b0;
        end else begin
            if (step_sec)  sec   <= sec_wrap ? 8'h00 : bcd_inc(sec);
            if (step_min)  min   <= min_wrap ? 8'h00 : bcd_inc(min);
            if (step_hour) hour  <= hour_nx;
            if (step_date) begin
                date <= date_wrap ? 8'h01 : bcd_inc(date);
                dow  <= dow_nx;
            end
            if (step_mon)  month <= mon_wrap ? 8'h01 : bcd_inc(month);
            if (step_year) year  <= (year == 8'h99) ? 8'h00 : bcd_inc(year);

            if (alarm_chk && match)      alarm_flag <= 1'b1;
            else if (we && addr == A_STAT) alarm_flag <= 1'b0;

            // host write wins over a step in the same cycle
            if (we) begin
                unique case (addr)
                    A_SEC:   sec   <= wdata & 8'h7F;
                    A_MIN:   min   <= wdata & 8'h7F;
                    A_HOUR:  hour  <= wdata & (h24 ? 8'h3F : 8'h9F);
                    A_DOW:   dow   <= wdata & 8'h07;
                    A_DATE:  date  <= wdata & 8'h3F;
                    A_MON:   month <= wdata & 8'h1F;
                    A_YEAR:  year  <= wdata;
                    A_ASEC:  asec  <= wdata & 8'h7F;
                    A_AMIN:  amin  <= wdata & 8'h7F;
                    A_AHOUR: ahour <= wdata;
                    A_CTRL: begin
                        freeze <= wdata[7];
                        h24    <= wdata[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_SEC:   rdata = sec;
            A_ASEC:  rdata = asec;
            A_MIN:   rdata = min;
            A_AMIN:  rdata = amin;
            A_HOUR:  rdata = hour;
            A_AHOUR: rdata = ahour;
            A_DOW:   rdata = dow;
            A_DATE:  rdata = date;
            A_MON:   rdata = month;
            A_YEAR:  rdata = year;
            A_BUSY:  rdata = {busy, 7'b0};
            A_CTRL:  rdata = {freeze, 5'b0, h24, 1'b0};
            A_STAT:  rdata = {2'b0, alarm_flag, 5'b0};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
    import clk_core_pkg::*;
#(
    parameter int UIP_LEAD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              uip,
    output logic              alarm_flag
);
    logic step_sec, step_min, step_hour, step_date, step_mon, step_year, alarm_chk;
    logic sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap;
    logic freeze_q;
    logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
    logic [7:0] asec_q, amin_q, ahour_q, last_date;

    clk_update_fsm #(.UIP_LEAD(UIP_LEAD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .freeze(freeze_q),
        .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap),
        .date_wrap(date_wrap), .mon_wrap(mon_wrap),
        .step_sec(step_sec), .step_min(step_min), .step_hour(step_hour),
        .step_date(step_date), .step_mon(step_mon), .step_year(step_year),
        .alarm_chk(alarm_chk), .busy(uip)
    );

    clk_month_limit u_mlim (
        .month(mon_q), .year(year_q), .last_date(last_date)
    );

    clk_time_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .step_sec(step_sec), .step_min(step_min), .step_hour(step_hour),
        .step_date(step_date), .step_mon(step_mon), .step_year(step_year),
        .alarm_chk(alarm_chk), .busy(uip), .last_date(last_date),
        .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap),
        .date_wrap(date_wrap), .mon_wrap(mon_wrap),
        .freeze(freeze_q), .alarm_flag(alarm_flag),
        .sec(sec_q), .min(min_q), .hour(hour_q), .dow(dow_q), .date(date_q),
        .month(mon_q), .year(year_q), .asec(asec_q), .amin(amin_q),
        .ahour(ahour_q)
    );
endmodule

// File: rtl/clk_core_chk.sv
module clk_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [3:0] reg_addr,
    input logic       uip,
    input logic       alarm_flag,
    input logic       freeze_q,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic [7:0] dow_q,
    input logic [7:0] date_q,
    input logic [7:0] asec_q,
    input logic [7:0] amin_q,
    input logic [7:0] ahour_q
);
    logic wr_sec;
    assign wr_sec = reg_we && (reg_addr == 4'h0);

    p_frozen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !wr_sec) |=> $stable(sec_q));

    p_step_inside_uip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sec_q) && !$past(wr_sec)) |-> $past(uip));

    p_alarm_on_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm_flag) && !$past(reg_we)) |->
        (sec_q == asec_q && min_q == amin_q && hour_q == ahour_q));

    p_dow_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dow_q) && !$past(reg_we)) |-> (dow_q >= 8'd1 && dow_q <= 8'd7));

    p_date_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(date_q) && !$past(reg_we)) |-> (date_q != 8'h00));
endmodule

bind bcd_clock_core clk_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .uip(uip), .alarm_flag(alarm_flag), .freeze_q(freeze_q),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dow_q(dow_q),
    .date_q(date_q), .asec_q(asec_q), .amin_q(amin_q), .ahour_q(ahour_q)
);

// File: tb/test_bcd_clock_core.sv
module test_bcd_clock_core;
    localparam int LEAD = 4;
    localparam int NV   = 26;

    // {req, h24, hr, mn, sc, dt, mo, yr, dw, ehr, emn, esc, edt, emo, eyr, edw}
    localparam logic [127:0] VEC [NV] = '{
        128'h03_01_12_34_56_15_06_21_03_12_34_57_15_06_21_03, // R3
        128'h03_01_12_34_09_15_06_21_03_12_34_10_15_06_21_03, // R3
        128'h04_01_10_59_59_15_06_21_03_11_00_00_15_06_21_03, // R4
        128'h04_01_09_59_59_15_06_21_03_10_00_00_15_06_21_03, // R4
        128'h04_01_19_59_59_15_06_21_03_20_00_00_15_06_21_03, // R4
        128'h08_01_23_59_59_15_06_21_07_00_00_00_16_06_21_01, // R8
        128'h08_01_23_59_59_09_09_21_02_00_00_00_10_09_21_03, // R8
        128'h06_01_23_59_59_30_04_21_02_00_00_00_01_05_21_03, // R6
        128'h06_01_23_59_59_31_01_21_02_00_00_00_01_02_21_03, // R6
        128'h06_01_23_59_59_30_09_21_04_00_00_00_01_10_21_05, // R6
        128'h06_01_23_59_59_31_12_99_05_00_00_00_01_01_00_06, // R6
        128'h06_01_23_59_59_30_05_21_01_00_00_00_31_05_21_02, // R6
        128'h07_01_23_59_59_28_02_24_01_00_00_00_29_02_24_02, // R7
        128'h07_01_23_59_59_29_02_24_01_00_00_00_01_03_24_02, // R7
        128'h07_01_23_59_59_28_02_23_01_00_00_00_01_03_23_02, // R7
        128'h07_01_23_59_59_28_02_10_01_00_00_00_01_03_10_02, // R7
        128'h07_01_23_59_59_28_02_12_01_00_00_00_29_02_12_02, // R7
        128'h07_01_23_59_59_28_02_00_01_00_00_00_29_02_00_02, // R7
        128'h07_01_23_59_59_28_02_96_01_00_00_00_29_02_96_02, // R7
        128'h07_01_23_59_59_28_02_98_01_00_00_00_01_03_98_02, // R7
        128'h05_00_11_59_59_15_06_21_03_92_00_00_15_06_21_03, // R5
        128'h05_00_92_59_59_15_06_21_03_81_00_00_15_06_21_03, // R5
        128'h05_00_91_59_59_15_06_21_03_12_00_00_16_06_21_04, // R5
        128'h05_00_12_59_59_15_06_21_03_01_00_00_15_06_21_03, // R5
        128'h05_00_09_59_59_15_06_21_03_10_00_00_15_06_21_03, // R5
        128'h05_00_89_30_00_15_06_21_03_89_30_01_15_06_21_03  // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       uip, alarm_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bcd_clock_core #(.UIP_LEAD(LEAD)) i_bcd_clock_core (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .uip(uip), .alarm_flag(alarm_flag)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic settle();
        repeat (20) @(posedge clk);
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 uip", {7'b0, uip}, 8'h00);
        check("R1 alarm_flag", {7'b0, alarm_flag}, 8'h00);
        rd(4'h0, v); check("R1 sec", v, 8'h00);
        rd(4'h2, v); check("R1 min", v, 8'h00);
        rd(4'h4, v); check("R1 hour", v, 8'h00);
        rd(4'h6, v); check("R1 dow", v, 8'h01);
        rd(4'h7, v); check("R1 date", v, 8'h01);
        rd(4'h8, v); check("R1 month", v, 8'h01);
        rd(4'h9, v); check("R1 year", v, 8'h00);
        rd(4'h5, v); check("R1 alarm hour", v, 8'h00);
        rd(4'hA, v); check("R1 busy reg", v, 8'h00);
        rd(4'hB, v); check("R1 control", v, 8'h02);
        rd(4'hC, v); check("R1 status", v, 8'h00);

        // R2: masking and read-only registers
        wr(4'hB, 8'h82);
        wr(4'h2, 8'hFF); rd(4'h2, v); check("R2 min mask", v, 8'h7F);
        wr(4'h0, 8'hFF); rd(4'h0, v); check("R2 sec mask", v, 8'h7F);
        wr(4'h4, 8'hFF); rd(4'h4, v); check("R2 hour24 mask", v, 8'h3F);
        wr(4'h7, 8'hFF); rd(4'h7, v); check("R2 date mask", v, 8'h3F);
        wr(4'h8, 8'hFF); rd(4'h8, v); check("R2 month mask", v, 8'h1F);
        wr(4'h6, 8'hFF); rd(4'h6, v); check("R2 dow mask", v, 8'h07);
        wr(4'hA, 8'hFF); rd(4'hA, v); check("R2 busy reg read-only", v, 8'h00);
        wr(4'hB, 8'hFF); rd(4'hB, v); check("R2 control bits", v, 8'h82);
        wr(4'hB, 8'h80);
        wr(4'h4, 8'hFF); rd(4'h4, v); check("R2 hour12 mask", v, 8'h9F);

        // vector table: rollover chains
        for (int i = 0; i < NV; i++) begin
            logic [127:0] e;
            logic [7:0] ctl;
            e = VEC[i];
            ctl = e[119:112][0] ? 8'h02 : 8'h00;
            wr(4'hB, 8'h80 | ctl);
            wr(4'h4, e[111:104]);
            wr(4'h2, e[103:96]);
            wr(4'h0, e[95:88]);
            wr(4'h7, e[87:80]);
            wr(4'h8, e[79:72]);
            wr(4'h9, e[71:64]);
            wr(4'h6, e[63:56]);
            wr(4'hB, ctl);
            pulse_tick();
            settle();
            rd(4'h4, v); check($sformatf("R%0d vec %0d hour", e[127:120], i), v, e[55:48]);
            rd(4'h2, v); check($sformatf("R%0d vec %0d min", e[127:120], i), v, e[47:40]);
            rd(4'h0, v); check($sformatf("R%0d vec %0d sec", e[127:120], i), v, e[39:32]);
            rd(4'h7, v); check($sformatf("R%0d vec %0d date", e[127:120], i), v, e[31:24]);
            rd(4'h8, v); check($sformatf("R%0d vec %0d month", e[127:120], i), v, e[23:16]);
            rd(4'h9, v); check($sformatf("R%0d vec %0d year", e[127:120], i), v, e[15:8]);
            rd(4'h6, v); check($sformatf("R%0d vec %0d dow", e[127:120], i), v, e[7:0]);
        end

        // R10: busy window timing
        wr(4'hB, 8'h82);
        wr(4'h4, 8'h08); wr(4'h2, 8'h30); wr(4'h0, 8'h20);
        wr(4'hB, 8'h02);
        @(negedge clk);
        reg_addr = 4'h0;
        sec_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sec_tick = 1'b0;
        check("R10 uip rises after tick", {7'b0, uip}, 8'h01);
        check("R10 sec held at start", reg_rdata, 8'h20);
        repeat (LEAD) @(posedge clk);
        @(negedge clk);
        check("R10 sec held through lead", reg_rdata, 8'h20);
        check("R10 uip high in lead", {7'b0, uip}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        check("R10 sec steps on lead+1 edge", reg_rdata, 8'h21);
        check("R10 uip still high", {7'b0, uip}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        check("R10 uip falls after update", {7'b0, uip}, 8'h00);

        // R9: freeze ignores ticks
        wr(4'hB, 8'h82);
        @(negedge clk); sec_tick = 1'b1;
        @(posedge clk);
        @(negedge clk); sec_tick = 1'b0;
        check("R9 uip low while frozen", {7'b0, uip}, 8'h00);
        settle();
        rd(4'h0, v); check("R9 sec held while frozen", v, 8'h21);
        // R9: freeze set in mid-update abandons it
        wr(4'hB, 8'h02);
        @(negedge clk); sec_tick = 1'b1;
        @(posedge clk);
        wr(4'hB, 8'h82);
        sec_tick = 1'b0;
        check("R9 uip drops on freeze", {7'b0, uip}, 8'h00);
        settle();
        rd(4'h0, v); check("R9 aborted update leaves sec", v, 8'h21);
        wr(4'hB, 8'h02);
        pulse_tick(); settle();
        rd(4'h0, v); check("R9 counting resumes", v, 8'h22);

        // R11: alarm match, clear, mismatch
        wr(4'hB, 8'h82);
        wr(4'h4, 8'h08); wr(4'h2, 8'h30); wr(4'h0, 8'h14);
        wr(4'h5, 8'h08); wr(4'h3, 8'h30); wr(4'h1, 8'h15);
        wr(4'hC, 8'h00);
        wr(4'hB, 8'h02);
        pulse_tick(); settle();
        check("R11 alarm_flag on match", {7'b0, alarm_flag}, 8'h01);
        rd(4'hC, v); check("R11 status bit 5", v, 8'h20);
        wr(4'hC, 8'h55);
        rd(4'hC, v); check("R11 status cleared", v, 8'h00);
        pulse_tick(); settle();
        check("R11 no flag on mismatch", {7'b0, alarm_flag}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule